// File: doc/BRIEF.md
# Flash Journal Save/Restore Controller

This controller keeps a small register value alive across power cycles by journaling it into one sector of word-wide non-volatile memory. Every save appends the value to a fresh data slot and then clears one bit in a header bitmap. Each header bit stands for one data slot. A cleared bit means the slot holds a valid entry. Because the header fills in order, the newest entry is always the last cleared bit.

After reset, the controller restores the value without any request. It reads header words in ascending order and skips every word that is fully used. In the first word that is not full, it counts the cleared bits to find the newest slot. It then reads that one data word. The data area itself is never searched. The sector is erased only when every slot has been used. A save is requested by the power-management logic just before the supply is removed. The restored value and a restore-done flag go to the register that the value belongs to.

Sector layout, with the default parameters:

- Header: words 0x00 to 0x0E.
- Data area: 240 slots at 0x10 to 0xFF.
- Slot mapping: slot n lives at word 0x10+n, and is marked by bit n%16 of header word n/16.

Top module: `nvlog_ctrl`

## Requirements
- R1: After reset is released, the controller issues flash reads of header words in ascending address order, starting at word 0x00. Each read is issued only after the previous read's `fl_done`.
- R2: A header word whose bit 15 reads 0 counts as 16 used slots, and the scan moves to the next header word. The scan stops at the first word whose bit 15 is 1. It also stops after word 0x0E, which means all 240 slots are used.
- R3: When the scan finds n used slots, the controller reads data word 0x10+n-1. It places bits [3:0] of that word on `restore_val`. Then `restore_done` rises and stays high until the next reset.
- R4: If header word 0x00 reads 0xFFFF, the controller issues no data read. `restore_val` is 0 when `restore_done` rises.
- R5: A header word that reads 0xFFFF after a fully used word means the newest entry is slot 16*k-1, where k is the number of fully used words.
- R6: A save with n slots used is done in two steps. First, program word 0x10+n with the value. Second, program header word n/16 with a mask that is all ones except bit n%16. After the save, n+1 slots count as used.
- R7: A data program writes `save_val` into bits [3:0] and zeros into bits [15:4].
- R8: A save with all 240 slots used first issues a sector erase, with `fl_addr` = 0. It then programs word 0x10 and programs header word 0x00 with 0xFFFE. An erase is never issued at any other time.
- R9: At most one flash operation is outstanding. A new `fl_req` comes only after `fl_done` for the previous one.
- R10: `save_done` is a one-cycle pulse in the cycle after the header program's `fl_done`. A `save_req` raised and dropped before `restore_done` rises causes no program or erase.
- R11: An entry whose stored data word is 0xFFFF is restored as 0xF. Its validity comes only from its header bit.
- R12: `fl_req` is a one-cycle pulse. `fl_op` encodes read=0, program=1, erase=2. `fl_op`, `fl_addr` and `fl_wdata` stay stable until `fl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| save_req | input | 1 | Save request, level; it is held until `save_done` |
| save_val | input | VAL_W (4) | Value to journal |
| save_done | output | 1 | One-cycle pulse when the save is complete |
| restore_done | output | 1 | High once the restore is complete |
| restore_val | output | VAL_W (4) | Restored value |
| fl_req | output | 1 | Flash operation request pulse |
| fl_op | output | 2 | Operation: 0 = read, 1 = program (AND), 2 = sector erase |
| fl_addr | output | ADDR_W (8) | Word address |
| fl_wdata | output | WORD_W (16) | Program data |
| fl_rdata | input | WORD_W (16) | Read data, valid with `fl_done` |
| fl_done | input | 1 | Operation complete, one-cycle pulse |

## Verification
The hardest states to reach from the ports are a full sector, where the save must erase first, and a header word boundary. In the boundary case the newest entry is the last bit of a full word, and the following header word is still all ones. Reaching these states by real saves would take hundreds of power cycles. The bench therefore preloads its behavioural flash with crafted header and data images, and then cycles reset. After that, it performs real saves across the 15→16 slot boundary and through the erase-on-full path. Each of these saves is followed by another restore.

// File: rtl/nvlog_pkg.sv
package nvlog_pkg;
  typedef enum logic [1:0] {
    FL_READ  = 2'd0,
    FL_PROG  = 2'd1,
    FL_ERASE = 2'd2
  } fl_op_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_HDR_WT,
    ST_DAT_WT,
    ST_IDLE,
    ST_ERS_WT,
    ST_PGD_WT,
    ST_PGH_WT
  } ctl_st_e;
endpackage

// File: rtl/nvlog_hdr_eval.sv
// Classifies one header word: fully used (top bit cleared) and number of cleared bits.
module nvlog_hdr_eval #(
  parameter int WORD_W = 16,
  localparam int ZC_W  = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              full_o,
  output logic [ZC_W-1:0]   zeros_o
);
  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < WORD_W; i++) begin
      zeros_o = zeros_o + {{(ZC_W-1){1'b0}}, ~word_i[i]};
    end
  end

  assign full_o = ~word_i[WORD_W-1];
endmodule

// File: rtl/nvlog_slot_map.sv
// Maps a slot index to its data address, header word address and header clear mask.
module nvlog_slot_map #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int SLOT_W    = 8,
  parameter int DATA_BASE = 16,
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic [WORD_W-1:0] hdr_mask_o
);
  assign data_addr_o = ADDR_W'(DATA_BASE) + ADDR_W'(slot_i);
  assign hdr_addr_o  = ADDR_W'(slot_i >> BIT_W);
  assign hdr_mask_o  = ~(WORD_W'(1) << slot_i[BIT_W-1:0]);
endmodule

// File: rtl/nvlog_fsm.sv
module nvlog_fsm
  import nvlog_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int HDR_WORDS = 15,
  parameter int DATA_BASE = 16,
  parameter int VAL_W     = 4,
  localparam int SLOTS    = HDR_WORDS * WORD_W,
  localparam int SLOT_W   = $clog2(SLOTS + 1),
  localparam int HI_W     = $clog2(HDR_WORDS),
  localparam int ZC_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              save_req_i,
  input  logic [VAL_W-1:0]  save_val_i,
  input  logic              fl_done_i,
  input  logic [VAL_W-1:0]  fl_rd_val_i,
  input  logic              hdr_full_i,
  input  logic [ZC_W-1:0]   hdr_zeros_i,
  input  logic [ADDR_W-1:0] wr_data_addr_i,
  input  logic [ADDR_W-1:0] wr_hdr_addr_i,
  input  logic [WORD_W-1:0] wr_hdr_mask_i,
  output logic [SLOT_W-1:0] save_slot_o,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [WORD_W-1:0] fl_wdata_o,
  output logic              save_done_o,
  output logic              restore_done_o,
  output logic [VAL_W-1:0]  restore_val_o
);
  ctl_st_e           state_q, state_d;
  logic [HI_W-1:0]   hidx_q, hidx_d;
  logic [SLOT_W-1:0] used_q, used_d;
  logic              req_q, req_d;
  fl_op_e            op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic [VAL_W-1:0]  val_q, val_d;
  logic              sdone_q, sdone_d;
  logic              rdone_q, rdone_d;
  logic [VAL_W-1:0]  rval_q, rval_d;
  logic [SLOT_W-1:0] tot;
  logic [SLOT_W-1:0] fetch_slot;

  always_comb begin
    tot        = hdr_full_i ? used_q + SLOT_W'(WORD_W) : used_q + SLOT_W'(hdr_zeros_i);
    fetch_slot = tot - SLOT_W'(1);
  end

  always_comb begin
    state_d = state_q;
    hidx_d  = hidx_q;
    used_d  = used_q;
    req_d   = 1'b0;
    op_d    = op_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    val_d   = val_q;
    sdone_d = 1'b0;
    rdone_d = rdone_q;
    rval_d  = rval_q;
    case (state_q)
      ST_BOOT: begin
        req_d   = 1'b1;
        op_d    = FL_READ;
        addr_d  = '0;
        hidx_d  = '0;
        used_d  = '0;
        state_d = ST_HDR_WT;
      end
      ST_HDR_WT: if (fl_done_i) begin
        used_d = tot;
        if (hdr_full_i && (hidx_q != HI_W'(HDR_WORDS - 1))) begin
          hidx_d = hidx_q + HI_W'(1);
          req_d  = 1'b1;
          op_d   = FL_READ;
          addr_d = ADDR_W'(hidx_q) + ADDR_W'(1);
        end else if (tot == '0) begin
          rval_d  = '0;
          rdone_d = 1'b1;
          state_d = ST_IDLE;
        end else begin
          req_d   = 1'b1;
          op_d    = FL_READ;
          addr_d  = ADDR_W'(DATA_BASE) + ADDR_W'(fetch_slot);
          state_d = ST_DAT_WT;
        end
      end
      ST_DAT_WT: if (fl_done_i) begin
        rval_d  = fl_rd_val_i;
        rdone_d = 1'b1;
        state_d = ST_IDLE;
      end
      ST_IDLE: if (save_req_i) begin
        val_d = save_val_i;
        req_d = 1'b1;
        if (used_q == SLOT_W'(SLOTS)) begin
          op_d    = FL_ERASE;
          addr_d  = '0;
          wdata_d = '1;
          used_d  = '0;
          state_d = ST_ERS_WT;
        end else begin
          op_d    = FL_PROG;
          addr_d  = wr_data_addr_i;
          wdata_d = WORD_W'(save_val_i);
          state_d = ST_PGD_WT;
        end
      end
      ST_ERS_WT: if (fl_done_i) begin
        req_d   = 1'b1;
        op_d    = FL_PROG;
        addr_d  = wr_data_addr_i;
        wdata_d = WORD_W'(val_q);
        state_d = ST_PGD_WT;
      end
      ST_PGD_WT: if (fl_done_i) begin
        req_d   = 1'b1;
        op_d    = FL_PROG;
        addr_d  = wr_hdr_addr_i;
        wdata_d = wr_hdr_mask_i;
        state_d = ST_PGH_WT;
      end
      ST_PGH_WT: if (fl_done_i) begin
        used_d  = used_q + SLOT_W'(1);
        sdone_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      hidx_q  <= '0;
      used_q  <= '0;
      req_q   <= 1'b0;
      op_q    <= FL_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      val_q   <= '0;
      sdone_q <= 1'b0;
      rdone_q <= 1'b0;
      rval_q  <= '0;
    end else begin
      state_q <= state_d;
      hidx_q  <= hidx_d;
      used_q  <= used_d;
      req_q   <= req_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      val_q   <= val_d;
      sdone_q <= sdone_d;
      rdone_q <= rdone_d;
      rval_q  <= rval_d;
    end
  end

  assign save_slot_o    = used_q;
  assign fl_req_o       = req_q;
  assign fl_op_o        = op_q;
  assign fl_addr_o      = addr_q;
  assign fl_wdata_o     = wdata_q;
  assign save_done_o    = sdone_q;
  assign restore_done_o = rdone_q;
  assign restore_val_o  = rval_q;

  // Outstanding-operation tracker used only by the checks below.
  logic pend_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (req_q)     pend_q <= 1'b1;
    else if (fl_done_i) pend_q <= 1'b0;
  end

  assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_q |-> !req_q);
  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !fl_done_i) |=> ($stable(addr_q) && $stable(op_q) && $stable(wdata_q)));
  assert_used_bound_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    used_q <= SLOT_W'(SLOTS));
  assert_erase_full_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_q && op_q == FL_ERASE) |-> $past(used_q) == SLOT_W'(SLOTS));
  assert_data_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_q && op_q == FL_PROG && addr_q >= ADDR_W'(DATA_BASE)) |-> wdata_q[WORD_W-1:VAL_W] == '0);
  assert_save_pulse_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    sdone_q |=> !sdone_q);
  assert_no_write_early_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_q && op_q != FL_READ) |-> rdone_q);
  assert_restore_sticky_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    rdone_q |=> rdone_q);
endmodule

// File: rtl/nvlog_ctrl.sv
module nvlog_ctrl #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int HDR_WORDS = 15,
  parameter int DATA_BASE = 16,
  parameter int VAL_W     = 4,
  localparam int SLOTS    = HDR_WORDS * WORD_W,
  localparam int SLOT_W   = $clog2(SLOTS + 1),
  localparam int ZC_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic [VAL_W-1:0]  save_val,
  output logic              save_done,
  output logic              restore_done,
  output logic [VAL_W-1:0]  restore_val,
  output logic              fl_req,
  output logic [1:0]        fl_op,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [WORD_W-1:0] fl_wdata,
  input  logic [WORD_W-1:0] fl_rdata,
  input  logic              fl_done
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic              hdr_full;
  logic [ZC_W-1:0]   hdr_zeros;
  logic [SLOT_W-1:0] save_slot;
  logic [ADDR_W-1:0] wr_data_addr;
  logic [ADDR_W-1:0] wr_hdr_addr;
  logic [WORD_W-1:0] wr_hdr_mask;

  nvlog_hdr_eval #(.WORD_W(WORD_W)) u_hdr_eval (
    .word_i  (fl_rdata),
    .full_o  (hdr_full),
    .zeros_o (hdr_zeros)
  );

  nvlog_slot_map #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_BASE(DATA_BASE)
  ) u_slot_map (
    .slot_i      (save_slot),
    .data_addr_o (wr_data_addr),
    .hdr_addr_o  (wr_hdr_addr),
    .hdr_mask_o  (wr_hdr_mask)
  );

  nvlog_fsm #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .HDR_WORDS(HDR_WORDS),
    .DATA_BASE(DATA_BASE), .VAL_W(VAL_W)
  ) u_fsm (
    .clk            (clk),
    .rst_ni         (rst_ni),
    .save_req_i     (save_req),
    .save_val_i     (save_val),
    .fl_done_i      (fl_done),
    .fl_rd_val_i    (fl_rdata[VAL_W-1:0]),
    .hdr_full_i     (hdr_full),
    .hdr_zeros_i    (hdr_zeros),
    .wr_data_addr_i (wr_data_addr),
    .wr_hdr_addr_i  (wr_hdr_addr),
    .wr_hdr_mask_i  (wr_hdr_mask),
    .save_slot_o    (save_slot),
    .fl_req_o       (fl_req),
    .fl_op_o        (fl_op),
    .fl_addr_o      (fl_addr),
    .fl_wdata_o     (fl_wdata),
    .save_done_o    (save_done),
    .restore_done_o (restore_done),
    .restore_val_o  (restore_val)
  );
endmodule

// File: tb/nvlog_ctrl_tb.sv
`timescale 1ns/1ps
module nvlog_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        save_req;
  logic [3:0]  save_val;
  logic        save_done, restore_done;
  logic [3:0]  restore_val;
  logic        fl_req;
  logic [1:0]  fl_op;
  logic [7:0]  fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] fl_rdata;
  logic        fl_done;

  always #2 clk = ~clk;

  nvlog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_val(save_val),
    .save_done(save_done), .restore_done(restore_done), .restore_val(restore_val),
    .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_done(fl_done)
  );

  logic [15:0] fmem [0:255];
  int eop[$], eaddr[$], edata[$];
  int n_chk = 0, n_fail = 0, lat = 1, cyc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural flash: AND-programming, erase to all ones, fixed latency.
  initial begin
    fl_done = 1'b0; fl_rdata = '0;
    forever begin
      @(posedge clk);
      fl_done <= 1'b0;
      if (fl_req) begin
        automatic int op = fl_op;
        automatic int a  = fl_addr;
        automatic logic [15:0] d = fl_wdata;
        repeat (lat) @(posedge clk);
        if (op == 0) fl_rdata <= fmem[a];
        else if (op == 1) fmem[a] = fmem[a] & d;
        else for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
        fl_done <= 1'b1;
      end
    end
  end

  // Reference comparison of every flash command on every clock.
  always @(negedge clk) begin
    if (rst_n && fl_req) begin
      if (eop.size() == 0) chk(0, "R9", "unexpected flash request op", fl_op, 99);
      else begin
        automatic int xo = eop.pop_front();
        automatic int xa = eaddr.pop_front();
        automatic int xd = edata.pop_front();
        chk(fl_op == xo, "R12", "flash op", fl_op, xo);
        chk(fl_addr == xa, "R1/R6", "flash address", fl_addr, xa);
        if (xd >= 0) chk(fl_wdata == xd, "R6/R7", "program data", fl_wdata, xd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WDOG", "watchdog cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int ref_used();
    for (int i = 0; i < 240; i++) if (fmem[i/16][i%16]) return i;
    return 240;
  endfunction

  task automatic push(int op, int a, int d);
    eop.push_back(op); eaddr.push_back(a); edata.push_back(d);
  endtask

  task automatic preload(int n);
    for (int i = 0; i < 256; i++) fmem[i] = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      fmem[i/16][i%16] = 1'b0;
      fmem[16+i] = 16'h1230 | 16'((i * 5 + 3) % 16);
    end
  endtask

  task automatic power_cycle(bit early_save, string tag);
    automatic int u = ref_used();
    automatic int nw = (u >= 240) ? 15 : u / 16 + 1;
    automatic int xv = (u > 0) ? int'(fmem[16 + u - 1][3:0]) : 0;
    automatic int w;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!fl_req && !restore_done && !save_done, "R3", "reset state outputs",
        {fl_req, restore_done, save_done}, 0);
    for (int i = 0; i < nw; i++) push(0, i, -1);
    if (u > 0) push(0, 16 + u - 1, -1);
    rst_n = 1'b1;
    if (early_save) begin
      save_val = 4'h6; save_req = 1'b1;
      repeat (3) @(negedge clk);
      save_req = 1'b0;
    end
    w = 0;
    while (!restore_done && w < 3000) begin @(negedge clk); w++; end
    chk(restore_done, tag, "restore_done rose", restore_done, 1);
    chk(restore_val == xv, tag, "restored value", restore_val, xv);
    chk(eop.size() == 0, "R1/R2", "pending expected reads", eop.size(), 0);
    if (early_save) chk(ref_used() == u, "R10", "slots used after early save_req", ref_used(), u);
    repeat (4) @(negedge clk);
    chk(restore_done, "R3", "restore_done held", restore_done, 1);
  endtask

  task automatic do_save(logic [3:0] v, string tag);
    automatic int u = ref_used();
    automatic int w = 0;
    if (u == 240) begin push(2, 0, -1); u = 0; end
    push(1, 16 + u, int'(v));
    push(1, u / 16, int'(~(16'h1 << (u % 16))));
    save_val = v; save_req = 1'b1;
    while (!save_done && w < 3000) begin @(negedge clk); w++; end
    save_req = 1'b0;
    chk(save_done, "R10", "save_done seen", save_done, 1);
    @(negedge clk);
    chk(!save_done, "R10", "save_done one cycle", save_done, 0);
    chk(eop.size() == 0, tag, "pending expected programs", eop.size(), 0);
    chk(fmem[16+u] == {12'h0, v}, "R7", "stored data word", fmem[16+u], {12'h0, v});
    chk(fmem[u/16][u%16] == 1'b0, "R6", "header bit cleared", fmem[u/16], u % 16);
    chk(ref_used() == u + 1, "R6", "slots used after save", ref_used(), u + 1);
  endtask

  initial begin
    rst_n = 1'b0; save_req = 1'b0; save_val = '0;
    preload(0);
    // R4: blank sector restores zero with a single header read.
    power_cycle(0, "R4");
    do_save(4'h5, "R6");
    power_cycle(0, "R3");
    // R10: save request during restore is ignored.
    lat = 3;
    power_cycle(1, "R10");
    // Word boundary: 15 used, then fill word 0, then cross into word 1.
    lat = 2;
    preload(15);
    power_cycle(0, "R2");
    do_save(4'hA, "R6");
    power_cycle(0, "R5");
    do_save(4'h3, "R6");
    power_cycle(0, "R2");
    // Full sector whose newest entry is all ones.
    preload(240);
    fmem[16+239] = 16'hFFFF;
    lat = 1;
    power_cycle(0, "R11");
    do_save(4'h9, "R8");
    power_cycle(0, "R8");
    // Several back-to-back saves with slow flash.
    lat = 3;
    for (int k = 0; k < 5; k++) do_save(4'(k * 3 + 1), "R6");
    power_cycle(0, "R3");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule